// File: doc/BRIEF.md
# Requester-ID to Stream-ID Translation Table

This block holds a small associative table that turns the 16-bit requester ID of a PCIe transaction (bus, device and function) into a 6-bit stream ID and a 3-bit controller ID. Those identifiers are the ones that downstream address-translation and interrupt-translation logic consume. Each of the 32 entries carries a requester ID, a per-bit compare mask, the two output identifiers and a valid flag.

Software never addresses the entries directly. It stages an entry in two data registers and then writes an access-control register. That write names an entry index, and its action bit decides the direction. With the bit set, the named entry is pulled into the data registers. With the bit clear, the staged data is committed into the named entry. Clearing an entry means committing all-zero data.

A separate lookup port takes a requester ID every clock. One clock later it returns hit, stream ID and controller ID from the lowest-numbered valid entry whose masked requester ID matches.

Top module: `rid_sid_xlate`

## Requirements
- R1: After reset the control, attribute and key registers all read zero, and every lookup misses.
- R2: The control register (address 0) holds an entry index in bits 4:0 and the fetch action in bit 16. It reads back only those bits, with all others zero.
- R3: A control write with bit 16 set copies the indexed entry into the attribute and key registers. The copy is readable on the cycle after the write.
- R4: The attribute register (address 1) has the valid flag in bit 31, the controller ID in bits 10:8 and the stream ID in bits 5:0. Every other bit reads as zero.
- R5: The key register (address 2) has the requester ID in bits 31:16 and the compare mask in bits 15:0, and it reads back exactly what was written. Address 3 reads zero and ignores writes.
- R6: A control write with bit 16 clear commits both data registers into the indexed entry only. It leaves the data registers and every other entry unchanged.
- R7: A mask bit of 1 makes the corresponding requester-ID bit take part in the compare, and a mask bit of 0 excludes it. An all-ones mask demands an exact match, and an all-zero mask matches any requester ID.
- R8: The lookup result is registered and appears one clock after the requester ID is presented. A commit is seen by a lookup presented in the clock after the control write.
- R9: When several valid entries match, the result comes from the lowest-numbered one.
- R10: When no valid entry matches, the lookup returns hit 0, stream ID 0 and controller ID 0. An entry with the valid flag clear never matches, whatever its key.
- R11: Committing all-zero data to an entry makes it invalid, so it stops matching, and a later fetch of that entry reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (0 control, 1 attribute, 2 key) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| lk_rid | input | 16 | Requester ID to translate |
| lk_hit | output | 1 | A valid entry matched (registered) |
| lk_sid | output | 6 | Stream ID of the winning entry, 0 on miss |
| lk_ctl | output | 3 | Controller ID of the winning entry, 0 on miss |

## Verification
The table is first filled with distinct exact-match entries, and each requester ID is looked up. This separates correct storage and routing of every index from aliasing between entries. Entries with partial, all-zero and single-bit masks are then layered over one another. An invalid entry whose key would match everything is also placed in the table. A sweep over all 65536 requester IDs is compared against a priority model in the bench. That sweep separates mask polarity errors, priority-order errors and valid-flag leaks. Fetch read-back after every commit, the write-then-lookup timing and the clear-by-zero sequence cover the indirect window itself.

// File: rtl/rsx_pkg.sv
package rsx_pkg;
  localparam int DW      = 32;
  localparam int RID_W   = 16;
  localparam int SID_W   = 6;
  localparam int CTL_W   = 3;
  localparam int IDX_FW  = 5;   // index field width in control register
  localparam int ACT_BIT = 16;  // fetch action
  localparam int VLD_BIT = 31;
  localparam int CTL_LSB = 8;
  localparam int SID_LSB = 0;
  localparam int RID_LSB = 16;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_ATTR = 2'd1,
    A_KEY  = 2'd2,
    A_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             vld;
    logic [CTL_W-1:0] ctl;
    logic [SID_W-1:0] sid;
    logic [RID_W-1:0] rid;
    logic [RID_W-1:0] msk;
  } entry_t;

  localparam logic [DW-1:0] ATTR_KEEP =
      (DW'(1) << VLD_BIT) |
      (DW'((1 << CTL_W) - 1) << CTL_LSB) |
      (DW'((1 << SID_W) - 1) << SID_LSB);

  function automatic logic [DW-1:0] attr_word(entry_t e);
    logic [DW-1:0] w;
    w = '0;
    w[VLD_BIT] = e.vld;
    w[CTL_LSB +: CTL_W] = e.ctl;
    w[SID_LSB +: SID_W] = e.sid;
    return w;
  endfunction

  function automatic logic [DW-1:0] key_word(entry_t e);
    return {e.rid, e.msk};
  endfunction

  function automatic entry_t entry_from_words(logic [DW-1:0] a, logic [DW-1:0] k);
    entry_t e;
    e.vld = a[VLD_BIT];
    e.ctl = a[CTL_LSB +: CTL_W];
    e.sid = a[SID_LSB +: SID_W];
    e.rid = k[RID_LSB +: RID_W];
    e.msk = k[0 +: RID_W];
    return e;
  endfunction

  // mask bit 1 = compare, 0 = don't care
  function automatic logic entry_hits(entry_t e, logic [RID_W-1:0] rid);
    return e.vld && (((rid ^ e.rid) & e.msk) == '0);
  endfunction
endpackage

// File: rtl/rsx_regs.sv
module rsx_regs
  import rsx_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [IDX_W-1:0] acc_idx,
  input  entry_t           fetch_entry,
  output logic             fetch_pulse,
  output logic             commit_pulse,
  output entry_t           commit_entry
);
  logic [IDX_FW-1:0] idx_q;
  logic              act_q;
  logic [DW-1:0]     attr_q;
  logic [DW-1:0]     key_q;
  logic              ctrl_wr;

  assign ctrl_wr      = reg_we && (reg_sel_e'(reg_addr) == A_CTRL);
  assign fetch_pulse  = ctrl_wr && reg_wdata[ACT_BIT];
  assign commit_pulse = ctrl_wr && !reg_wdata[ACT_BIT];
  assign acc_idx      = reg_wdata[IDX_W-1:0];
  assign commit_entry = entry_from_words(attr_q, key_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      act_q  <= 1'b0;
      attr_q <= '0;
      key_q  <= '0;
    end else if (reg_we) begin
      unique case (reg_sel_e'(reg_addr))
        A_CTRL: begin
          idx_q <= reg_wdata[IDX_FW-1:0];
          act_q <= reg_wdata[ACT_BIT];
          if (reg_wdata[ACT_BIT]) begin
            attr_q <= attr_word(fetch_entry);
            key_q  <= key_word(fetch_entry);
          end
        end
        A_ATTR:  attr_q <= reg_wdata & ATTR_KEEP;
        A_KEY:   key_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel_e'(reg_addr))
      A_CTRL: begin
        reg_rdata[IDX_FW-1:0] = idx_q;
        reg_rdata[ACT_BIT]    = act_q;
      end
      A_ATTR:  reg_rdata = attr_q;
      A_KEY:   reg_rdata = key_q;
      default: reg_rdata = '0;
    endcase
  end

  p_fetch_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pulse |=> (attr_q == attr_word($past(fetch_entry))) && (key_q == key_word($past(fetch_entry))));
  p_attr_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_q & ~ATTR_KEEP) == '0);
  p_commit_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> $stable(attr_q) && $stable(key_q));
endmodule

// File: rtl/rsx_store.sv
module rsx_store
  import rsx_pkg::*;
#(
  parameter int N_ENT = 32,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [IDX_W-1:0] idx,
  input  entry_t           wentry,
  output entry_t           rentry,
  output entry_t           ents [N_ENT]
);
  logic [N_ENT-1:0] wsel;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign wsel[i] = commit && (idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) ents[i] <= '0;
      else if (wsel[i]) ents[i] <= wentry;
    end
  end

  assign rentry = ents[idx];

  p_one_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel));
  p_commit_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ents[$past(idx)] == $past(wentry));
endmodule

// File: rtl/rsx_match.sv
module rsx_match
  import rsx_pkg::*;
#(
  parameter int N_ENT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  entry_t           ents [N_ENT],
  input  logic [RID_W-1:0] rid,
  output logic [N_ENT-1:0] hit_vec,
  output logic             hit_q,
  output logic [SID_W-1:0] sid_q,
  output logic [CTL_W-1:0] ctl_q
);
  logic             any_hit;
  logic [SID_W-1:0] sid_d;
  logic [CTL_W-1:0] ctl_d;

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hit_vec[i] = entry_hits(ents[i], rid);
  end

  // scan from the top so the lowest index is written last
  always_comb begin
    any_hit = 1'b0;
    sid_d   = '0;
    ctl_d   = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        sid_d   = ents[i].sid;
        ctl_d   = ents[i].ctl;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      sid_q <= '0;
      ctl_q <= '0;
    end else begin
      hit_q <= any_hit;
      sid_q <= sid_d;
      ctl_q <= ctl_d;
    end
  end

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_q |-> (sid_q == '0) && (ctl_q == '0));
  p_hit_has_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_vec) == '0 |-> !hit_q);
  p_first_entry_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_vec[0]) |-> hit_q && sid_q == $past(ents[0].sid) && ctl_q == $past(ents[0].ctl));
endmodule

// File: rtl/rid_sid_xlate.sv
module rid_sid_xlate
  import rsx_pkg::*;
#(
  parameter int N_ENT = 32,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [15:0]      lk_rid,
  output logic             lk_hit,
  output logic [5:0]       lk_sid,
  output logic [2:0]       lk_ctl
);
  logic [IDX_W-1:0] acc_idx;
  logic             fetch_pulse;
  logic             commit_pulse;
  entry_t           commit_entry;
  entry_t           fetch_entry;
  entry_t           ents [N_ENT];
  logic [N_ENT-1:0] hit_vec;

  rsx_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_idx(acc_idx),
    .fetch_entry(fetch_entry), .fetch_pulse(fetch_pulse),
    .commit_pulse(commit_pulse), .commit_entry(commit_entry)
  );

  rsx_store #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit_pulse), .idx(acc_idx),
    .wentry(commit_entry), .rentry(fetch_entry), .ents(ents)
  );

  rsx_match #(.N_ENT(N_ENT)) u_match (
    .clk(clk), .rst_n(rst_n), .ents(ents), .rid(lk_rid), .hit_vec(hit_vec),
    .hit_q(lk_hit), .sid_q(lk_sid), .ctl_q(lk_ctl)
  );

  p_clear_invalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && !commit_entry.vld) |=> !hit_vec[$past(acc_idx)]);
endmodule

// File: tb/tb_rid_sid_xlate.sv
module tb_rid_sid_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] lk_rid = '0;
  logic        lk_hit;
  logic [5:0]  lk_sid;
  logic [2:0]  lk_ctl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic        m_vld [32];
  logic [2:0]  m_ctl [32];
  logic [5:0]  m_sid [32];
  logic [15:0] m_rid [32];
  logic [15:0] m_msk [32];

  rid_sid_xlate dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_rid(lk_rid),
    .lk_hit(lk_hit), .lk_sid(lk_sid), .lk_ctl(lk_ctl)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  function automatic logic [12:0] model(input logic [15:0] r);
    for (int i = 0; i < 32; i++)
      if (m_vld[i] && (((r ^ m_rid[i]) & m_msk[i]) == 16'h0))
        return {1'b1, m_ctl[i], 3'b000, m_sid[i]};
    return 13'h0;
  endfunction

  task automatic look(input string req, input logic [15:0] r);
    logic [12:0] e;
    lk_rid = r;
    @(posedge clk); @(negedge clk);
    e = model(r);
    check(req, {19'h0, lk_hit, lk_ctl, 3'b000, lk_sid}, {19'h0, e});
  endtask

  task automatic prog(input int idx, input logic v, input logic [2:0] c, input logic [5:0] s,
                      input logic [15:0] r, input logic [15:0] m);
    wr(2'd1, {v, 20'h0, c, 2'b00, s});
    wr(2'd2, {r, m});
    wr(2'd0, 32'(idx));
    m_vld[idx] = v; m_ctl[idx] = c; m_sid[idx] = s; m_rid[idx] = r; m_msk[idx] = m;
  endtask

  initial begin
    #(190000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_vld[i] = 0; m_ctl[i] = 0; m_sid[i] = 0; m_rid[i] = 0; m_msk[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_check("R1 ctrl", 2'd0, 32'h0);
    rd_check("R1 attr", 2'd1, 32'h0);
    rd_check("R1 key", 2'd2, 32'h0);
    look("R1 miss after reset", 16'h0000);
    look("R1 miss after reset", 16'hFFFF);

    // R4 attribute layout: valid 31, ctl 10:8, sid 5:0
    wr(2'd1, 32'hFFFF_FFFF);
    rd_check("R4 attr reserved zero", 2'd1, 32'h8000_073F);
    // R5 key layout, address 3
    wr(2'd2, 32'h1234_ABCD);
    rd_check("R5 key readback", 2'd2, 32'h1234_ABCD);
    wr(2'd3, 32'hDEAD_BEEF);
    rd_check("R5 addr3 reads zero", 2'd3, 32'h0);
    rd_check("R5 addr3 write ignored", 2'd2, 32'h1234_ABCD);
    // R2 control: fetch bit 16, index 4:0; R3 fetch of empty entry 31
    wr(2'd0, 32'hFFFF_FFFF);
    rd_check("R2 ctrl fields", 2'd0, 32'h0001_001F);
    rd_check("R3 fetch empty attr", 2'd1, 32'h0);
    rd_check("R3 fetch empty key", 2'd2, 32'h0);

    // fill all entries with exact keys
    for (int i = 0; i < 32; i++)
      prog(i, 1'b1, 3'(i % 8), 6'((i * 7 + 3) % 64), 16'h0100 + 16'(i * 17), 16'hFFFF);
    rd_check("R6 data kept after commit", 2'd2, {16'h0100 + 16'(31 * 17), 16'hFFFF});
    for (int i = 0; i < 32; i++) begin
      wr(2'd0, 32'h0001_0000 | 32'(i));
      rd_check("R3 R6 fetch attr", 2'd1, {1'b1, 20'h0, 3'(i % 8), 2'b00, 6'((i * 7 + 3) % 64)});
      rd_check("R3 R6 fetch key", 2'd2, {16'h0100 + 16'(i * 17), 16'hFFFF});
    end
    for (int i = 0; i < 32; i++) look("R7 exact match", 16'h0100 + 16'(i * 17));
    look("R10 no match", 16'h0101);
    look("R10 no match", 16'hF000);

    // R8 timing: commit then lookup in the next clock; output registered
    look("R8 before", 16'h4444);
    prog(7, 1'b1, 3'd5, 6'd42, 16'h4444, 16'hFFFF);
    lk_rid = 16'h4444; #1;
    check("R8 output holds until edge", {31'h0, lk_hit}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8 commit seen next clock", {23'h0, lk_hit, lk_ctl, lk_sid}, {23'h0, 1'b1, 3'd5, 6'd42});

    // R7 partial masks, R9 priority, R10 invalid entry
    prog(5, 1'b1, 3'd1, 6'd11, 16'h3300, 16'hFF00);
    prog(3, 1'b0, 3'd7, 6'd63, 16'h0000, 16'h0000);
    prog(9, 1'b1, 3'd2, 6'd22, 16'h8000, 16'h8000);
    prog(20, 1'b1, 3'd3, 6'd33, 16'h5A5A, 16'h0000);
    prog(6, 1'b1, 3'd4, 6'd44, 16'h3355, 16'hFFFF);
    for (int v = 0; v < 256; v++) look("R7 R9 masked byte", 16'h3300 | 16'(v));
    look("R9 overlapping low wins", 16'h3355);
    look("R10 invalid never matches", 16'h0000);

    // R11 clear entry 5
    prog(5, 1'b0, 3'd0, 6'd0, 16'h0000, 16'h0000);
    wr(2'd0, 32'h0001_0005);
    rd_check("R11 cleared attr", 2'd1, 32'h0);
    rd_check("R11 cleared key", 2'd2, 32'h0);
    look("R11 cleared no longer wins", 16'h3300);

    // exhaustive sweep against the model
    for (int v = 0; v < 65536; v++) look("R7 R9 R10 sweep", 16'(v));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule